// File: doc/BRIEF.md
# Palette DAC Host Register Front End with Concealed Indirect Bank

This block sits between an 8-bit host register bus and the rest of a palette DAC. It offers two direct registers, chosen by a 1-bit select: the palette write-address register (`sel = 0`) and the pixel mask register (`sel = 1`). A bank of six indirect registers is hidden behind the pixel mask. Software reaches the bank only by reading the pixel mask several times in a row. Any access to the write-address register, and any write at all, cancels the sequence.

A sequencer state machine counts the reads. It has four states:
- `SQ_IDLE`: no reads counted.
- `SQ_COUNT`: one to three arming reads seen.
- `SQ_ARMED`: the pointer selects an indirect register.
- `SQ_DEAD`: the pointer has run past the last index.

It has these transitions:
- *first read*: `SQ_IDLE`→`SQ_COUNT`.
- *arming read*: `SQ_COUNT`→`SQ_COUNT`, count up.
- *fourth read*: `SQ_COUNT`→`SQ_ARMED`, pointer 0.
- *advance*: `SQ_ARMED`→`SQ_ARMED`, pointer up.
- *overrun*: `SQ_ARMED`→`SQ_DEAD` on a read at index 5.
- *dead read*: `SQ_DEAD`→`SQ_DEAD`.
- *restart*: any state→`SQ_IDLE`, on any pixel-mask write or any write-address access.

Control register 0 drives three outputs: the sleep output, the clock-doubler output and the 8-bit colour-word output.

Top module: `pdac_regfront`

## Requirements
- R1: A synchronous active-high `rst` clears control register 0, the pixel mask, the write-address register and the sequencer. After reset, `sleep`, `dbl_clk` and `col8` are 0 and a pixel-mask read returns 0x00.
- R2: A read strobe returns its data on `rdata` with `rvalid` high in the following cycle. `sel=0` reads the write-address register and `sel=1` reads the pixel mask or the indirect bank. A write with `sel=0` stores `wdata` into the write-address register.
- R3: Starting from `SQ_IDLE`, the first four consecutive pixel-mask reads return the pixel mask. The fifth pixel-mask access targets indirect index 0, which is control register 0.
- R4: Each further pixel-mask read advances the pointer by one. With N extra reads after the four arming reads, the next pixel-mask access targets the register at index N. The indices are:
  - 1: manufacturer identification.
  - 2: device identification.
  - 3: red signature.
  - 4: green signature.
  - 5: blue signature.
- R5: While armed, a pixel-mask write goes to the selected indirect register. It leaves the pixel mask unchanged and returns the sequencer to `SQ_IDLE`, so the next read returns the pixel mask again.
- R6: Before arming, a pixel-mask write updates the pixel mask and restarts the arming count from zero.
- R7: Any read or write with `sel=0` restarts the arming count from zero.
- R8: In control register 0, bit 2 drives `sleep`, bit 5 drives `dbl_clk` and bit 1 drives `col8`. Writing 0 to a bit clears its output.
- R9: Index 1 returns parameter `MFG_ID` (default 0x5A) and index 2 returns `DEV_ID` (default 0xC3). Writes to either index are ignored, and control register 0 keeps its value.
- R10: Indices 3, 4 and 5 return the current values of `sig_red`, `sig_grn` and `sig_blu`. Writes to these indices are ignored.
- R11: A read at index 5 moves the sequencer to `SQ_DEAD`. In `SQ_DEAD`, pixel-mask reads return 0x00 and a pixel-mask write changes no register and restarts the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_stb | input | 1 | Single-cycle read strobe |
| wr_stb | input | 1 | Single-cycle write strobe |
| sel | input | 1 | Direct register select: 0 write address, 1 pixel mask |
| wdata | input | 8 | Write data |
| sig_red | input | 8 | Red signature value |
| sig_grn | input | 8 | Green signature value |
| sig_blu | input | 8 | Blue signature value |
| rdata | output | 8 | Read data, valid with rvalid |
| rvalid | output | 1 | High the cycle after a read strobe |
| pix_mask | output | 8 | Current pixel mask register |
| pal_waddr | output | 8 | Current palette write address |
| sleep | output | 1 | Power-down request |
| dbl_clk | output | 1 | 2x8-bit port with internal clock doubler |
| col8 | output | 1 | 8-bit colour words instead of 6-bit |

## Verification
The assertions assume that `rd_stb` and `wr_stb` are never high in the same cycle. The stimulus respects this because every host access is issued by a task that raises exactly one strobe for one cycle. The assertions also assume that `sel` and `wdata` are meaningful only while a strobe is high, and the tasks change them only together with a strobe. The signature inputs are changed only between accesses, so each expected value pushed for a signature read matches the input value at the strobe.

// File: rtl/pdac_pkg.sv
package pdac_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_COUNT = 2'd1,
        SQ_ARMED = 2'd2,
        SQ_DEAD  = 2'd3
    } seq_state_t;

    localparam int IDX_CTRL = 0;
    localparam int IDX_MFG  = 1;
    localparam int IDX_DEV  = 2;
    localparam int IDX_SIGR = 3;
    localparam int IDX_SIGG = 4;
    localparam int IDX_SIGB = 5;

    localparam int BIT_COL8  = 1;
    localparam int BIT_SLEEP = 2;
    localparam int BIT_DBL   = 5;
endpackage

// File: rtl/pdac_seq.sv
module pdac_seq
    import pdac_pkg::*;
#(
    parameter int ARM_READS = 4,
    parameter int N_IND     = 6,
    localparam int CW = $clog2(ARM_READS),
    localparam int IW = $clog2(N_IND)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_pm,
    input  logic          wr_pm,
    input  logic          touch_addr,
    output logic          armed,
    output logic          dead,
    output logic [IW-1:0] idx
);
    seq_state_t    st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [IW-1:0] ptr_q, ptr_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        ptr_d = ptr_q;
        if (wr_pm || touch_addr) begin
            st_d  = SQ_IDLE;
            cnt_d = '0;
            ptr_d = '0;
        end else if (rd_pm) begin
            unique case (st_q)
                SQ_IDLE: begin
                    st_d  = SQ_COUNT;
                    cnt_d = CW'(1);
                end
                SQ_COUNT: begin
                    if (cnt_q == CW'(ARM_READS - 1)) begin
                        st_d  = SQ_ARMED;
                        ptr_d = '0;
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
                SQ_ARMED: begin
                    if (ptr_q == IW'(N_IND - 1))
                        st_d = SQ_DEAD;
                    else
                        ptr_d = ptr_q + IW'(1);
                end
                SQ_DEAD: st_d = SQ_DEAD;
                default: st_d = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= SQ_IDLE;
            cnt_q <= '0;
            ptr_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            ptr_q <= ptr_d;
        end
    end

    always_comb begin
        armed = (st_q == SQ_ARMED);
        dead  = (st_q == SQ_DEAD);
        idx   = ptr_q;
    end

    AST_ADDR_RESTART: assert property (@(posedge clk) disable iff (rst)
        touch_addr |=> (st_q == SQ_IDLE)); // R7
    AST_PTR_BOUND: assert property (@(posedge clk) disable iff (rst)
        (st_q == SQ_ARMED) |-> (ptr_q < IW'(N_IND))); // R4
    AST_ARM_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(armed) |-> (idx == '0)); // R3
    AST_DEAD_STICKY: assert property (@(posedge clk) disable iff (rst)
        (dead && !wr_pm && !touch_addr) |=> dead); // R11
endmodule

// File: rtl/pdac_ibank.sv
module pdac_ibank
    import pdac_pkg::*;
#(
    parameter int          DW     = 8,
    parameter int          N_IND  = 6,
    parameter logic [DW-1:0] MFG_ID = 8'h5A,
    parameter logic [DW-1:0] DEV_ID = 8'hC3,
    localparam int IW = $clog2(N_IND)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] sig_red,
    input  logic [DW-1:0] sig_grn,
    input  logic [DW-1:0] sig_blu,
    output logic [DW-1:0] ctrl,
    output logic [DW-1:0] rd_val
);
    logic [DW-1:0] ctrl_q;
    logic          ctrl_we;

    assign ctrl_we = we && (idx == IW'(IDX_CTRL));

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (ctrl_we)
            ctrl_q <= wdata;
    end

    always_comb begin
        unique case (int'(idx))
            IDX_CTRL: rd_val = ctrl_q;
            IDX_MFG:  rd_val = MFG_ID;
            IDX_DEV:  rd_val = DEV_ID;
            IDX_SIGR: rd_val = sig_red;
            IDX_SIGG: rd_val = sig_grn;
            IDX_SIGB: rd_val = sig_blu;
            default:  rd_val = '0;
        endcase
        ctrl = ctrl_q;
    end

    AST_CTRL_GUARD: assert property (@(posedge clk) disable iff (rst)
        !(we && idx == IW'(IDX_CTRL)) |=> $stable(ctrl_q)); // R9
endmodule

// File: rtl/pdac_regfront.sv
module pdac_regfront
    import pdac_pkg::*;
#(
    parameter int          DW        = 8,
    parameter int          ARM_READS = 4,
    parameter int          N_IND     = 6,
    parameter logic [DW-1:0] MFG_ID  = 8'h5A,
    parameter logic [DW-1:0] DEV_ID  = 8'hC3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_stb,
    input  logic          wr_stb,
    input  logic          sel,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] sig_red,
    input  logic [DW-1:0] sig_grn,
    input  logic [DW-1:0] sig_blu,
    output logic [DW-1:0] rdata,
    output logic          rvalid,
    output logic [DW-1:0] pix_mask,
    output logic [DW-1:0] pal_waddr,
    output logic          sleep,
    output logic          dbl_clk,
    output logic          col8
);
    localparam int IW = $clog2(N_IND);

    logic          rd_pm, wr_pm, touch_addr;
    logic          armed, dead;
    logic [IW-1:0] idx;
    logic [DW-1:0] ctrl, bank_rd;
    logic [DW-1:0] pmask_q, waddr_q, rdata_q;
    logic          rvalid_q;

    assign rd_pm      = rd_stb && sel;
    assign wr_pm      = wr_stb && sel;
    assign touch_addr = (rd_stb || wr_stb) && !sel;

    pdac_seq #(.ARM_READS(ARM_READS), .N_IND(N_IND)) u_seq (
        .clk(clk), .rst(rst), .rd_pm(rd_pm), .wr_pm(wr_pm),
        .touch_addr(touch_addr), .armed(armed), .dead(dead), .idx(idx)
    );

    pdac_ibank #(.DW(DW), .N_IND(N_IND), .MFG_ID(MFG_ID), .DEV_ID(DEV_ID)) u_bank (
        .clk(clk), .rst(rst), .we(wr_pm && armed), .idx(idx), .wdata(wdata),
        .sig_red(sig_red), .sig_grn(sig_grn), .sig_blu(sig_blu),
        .ctrl(ctrl), .rd_val(bank_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pmask_q  <= '0;
            waddr_q  <= '0;
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= rd_stb;
            if (wr_pm && !armed && !dead)
                pmask_q <= wdata;
            if (wr_stb && !sel)
                waddr_q <= wdata;
            if (rd_stb) begin
                if (!sel)
                    rdata_q <= waddr_q;
                else if (dead)
                    rdata_q <= '0;
                else if (armed)
                    rdata_q <= bank_rd;
                else
                    rdata_q <= pmask_q;
            end
        end
    end

    always_comb begin
        rdata     = rdata_q;
        rvalid    = rvalid_q;
        pix_mask  = pmask_q;
        pal_waddr = waddr_q;
        sleep     = ctrl[BIT_SLEEP];
        dbl_clk   = ctrl[BIT_DBL];
        col8      = ctrl[BIT_COL8];
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(rd_stb && wr_stb)); // R2
    AST_DEAD_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_pm && dead) |=> (rdata == '0)); // R11
    AST_PMASK_SHIELD: assert property (@(posedge clk) disable iff (rst)
        (wr_pm && (armed || dead)) |=> $stable(pix_mask)); // R5
    AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        rvalid |-> $past(rd_stb)); // R2
endmodule

// File: tb/sim_pdac_regfront.sv
module sim_pdac_regfront;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rd_stb = 1'b0, wr_stb = 1'b0, sel = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] sig_red = 8'h31, sig_grn = 8'h62, sig_blu = 8'h93;
    logic [7:0] rdata, pix_mask, pal_waddr;
    logic       rvalid, sleep, dbl_clk, col8;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    pdac_regfront u0 (
        .clk(clk), .rst(rst), .rd_stb(rd_stb), .wr_stb(wr_stb), .sel(sel),
        .wdata(wdata), .sig_red(sig_red), .sig_grn(sig_grn), .sig_blu(sig_blu),
        .rdata(rdata), .rvalid(rvalid), .pix_mask(pix_mask), .pal_waddr(pal_waddr),
        .sleep(sleep), .dbl_clk(dbl_clk), .col8(col8)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rvalid) begin
            if (exp_q.size() == 0) begin
                check("R2 unexpected rvalid", 8'h01, 8'h00);
            end else begin
                check(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
    end

    task automatic rd(input logic s, input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        sel = s; rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic wr(input logic s, input logic [7:0] d);
        sel = s; wdata = d; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic arm(input logic [7:0] pm, input string tag);
        for (int i = 0; i < 4; i++) rd(1'b1, pm, tag);
    endtask

    task automatic finish_run();
        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) check("R2 reads outstanding", 8'(exp_q.size()), 8'h00);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(negedge clk);
        check("watchdog expired", 8'h01, 8'h00);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 sleep", {7'd0, sleep}, 8'h00);
        check("R1 dbl_clk", {7'd0, dbl_clk}, 8'h00);
        check("R1 col8", {7'd0, col8}, 8'h00);
        rd(1'b1, 8'h00, "R1 pixel mask after reset");
        rd(1'b0, 8'h00, "R1 write address after reset");
        // R2 write address register
        wr(1'b0, 8'h37);
        check("R2 pal_waddr", pal_waddr, 8'h37);
        rd(1'b0, 8'h37, "R2 write address readback");
        // R6 write before arming
        wr(1'b1, 8'hA5);
        check("R6 pix_mask", pix_mask, 8'hA5);
        // R3 arming, R4 walk, R9 ids, R10 signatures, R11 overrun
        arm(8'hA5, "R3 arming read returns mask");
        rd(1'b1, 8'h00, "R3 fifth read is ctrl");
        rd(1'b1, 8'h5A, "R4 R9 manufacturer id");
        rd(1'b1, 8'hC3, "R4 R9 device id");
        rd(1'b1, 8'h31, "R4 R10 red signature");
        rd(1'b1, 8'h62, "R4 R10 green signature");
        rd(1'b1, 8'h93, "R4 R10 blue signature");
        rd(1'b1, 8'h00, "R11 read past end");
        rd(1'b1, 8'h00, "R11 second read past end");
        wr(1'b1, 8'hEE);
        check("R11 dead write leaves mask", pix_mask, 8'hA5);
        check("R11 dead write leaves ctrl", {7'd0, sleep}, 8'h00);
        rd(1'b1, 8'hA5, "R11 sequence restarted after dead write");
        rd(1'b0, 8'h37, "R7 address read");
        // R5 R8 write ctrl at index 0
        arm(8'hA5, "R3 arming");
        wr(1'b1, 8'h26);
        check("R8 sleep bit2", {7'd0, sleep}, 8'h01);
        check("R8 dbl_clk bit5", {7'd0, dbl_clk}, 8'h01);
        check("R8 col8 bit1", {7'd0, col8}, 8'h01);
        check("R5 mask untouched", pix_mask, 8'hA5);
        rd(1'b1, 8'hA5, "R5 sequence reset after indirect write");
        // R6 restart by mask write
        rd(1'b1, 8'hA5, "R6 pre-write read");
        wr(1'b1, 8'h11);
        arm(8'h11, "R6 count restarted");
        rd(1'b1, 8'h26, "R6 ctrl after four fresh reads");
        wr(1'b0, 8'h40);
        // R7 address read and write restart the count
        rd(1'b1, 8'h11, "R7 pre");
        rd(1'b1, 8'h11, "R7 pre");
        rd(1'b1, 8'h11, "R7 pre");
        rd(1'b0, 8'h40, "R7 address read cancels");
        rd(1'b1, 8'h11, "R7 pre");
        rd(1'b1, 8'h11, "R7 pre");
        rd(1'b1, 8'h11, "R7 pre");
        wr(1'b0, 8'h41);
        arm(8'h11, "R7 count restarted");
        rd(1'b1, 8'h26, "R7 ctrl after restart");
        // R9 write to id ignored
        rd(1'b0, 8'h41, "R7 address");
        arm(8'h11, "R9 arming");
        rd(1'b1, 8'h26, "R9 ctrl");
        wr(1'b1, 8'hFF);
        check("R9 ctrl kept sleep", {7'd0, sleep}, 8'h01);
        check("R9 mask kept", pix_mask, 8'h11);
        arm(8'h11, "R9 arming");
        rd(1'b1, 8'h26, "R9 ctrl unchanged");
        rd(1'b1, 8'h5A, "R9 manufacturer id unchanged");
        wr(1'b1, 8'h00);
        arm(8'h11, "R9 arming");
        rd(1'b1, 8'h26, "R9 ctrl unchanged after id write");
        rd(1'b1, 8'h5A, "R9 mfg");
        rd(1'b1, 8'hC3, "R9 device id unchanged");
        // R10 signatures track inputs, writes ignored
        rd(1'b1, 8'h31, "R10 red");
        wr(1'b1, 8'h00);
        sig_grn = 8'h7C;
        arm(8'h11, "R10 arming");
        rd(1'b1, 8'h26, "R10 ctrl");
        rd(1'b1, 8'h5A, "R10 mfg");
        rd(1'b1, 8'hC3, "R10 dev");
        rd(1'b1, 8'h31, "R10 red after write");
        rd(1'b1, 8'h7C, "R10 green follows input");
        // R8 wake
        rd(1'b0, 8'h41, "R7 address");
        arm(8'h11, "R8 arming");
        wr(1'b1, 8'h00);
        check("R8 sleep cleared", {7'd0, sleep}, 8'h00);
        check("R8 dbl_clk cleared", {7'd0, dbl_clk}, 8'h00);
        check("R8 col8 cleared", {7'd0, col8}, 8'h00);
        // R1 reset mid-sequence
        arm(8'h11, "R1 arming");
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 mask cleared", pix_mask, 8'h00);
        rd(1'b1, 8'h00, "R1 sequence cleared by reset");
        finish_run();
    end
endmodule